// File: doc/BRIEF.md
# In-band Xon/Xoff Flow Controller

This block sits next to a UART's shifters and carries out software (in-band) flow control. Two programmable character values stand for "pause" (Xoff) and "resume" (Xon). Each received character is compared against both values. A match is flagged so that the receive path discards the character, and it also sets or clears a hold on the local transmitter. The transmitter finishes the character it is already sending and does not start another data character while the hold is set.

On the transmit side, the block watches the fill count of the local receive buffer. When the count reaches an upper threshold, it asks the transmitter to send Xoff. When the count later drops below a lower threshold, it asks for Xon. An inserted control character goes ahead of any queued data character. The request stays up until the transmitter accepts it. A single enable input turns the feature on and off. With the enable low, every character passes as ordinary data and no hold or request is active.

Top module: `inband_flow_ctrl`

## Requirements
- R1: After reset `tx_hold` is 0, `ins_req` is 0 and `data_go` is 1.
- R2: When `fc_en` is 1 and a valid received character equals `xoff_char`, `rx_drop` is 1 in that same cycle, and `tx_hold` is 1 from the next cycle until an Xon is received or `fc_en` falls.
- R3: When `fc_en` is 1 and a valid received character equals `xon_char` (and not `xoff_char`), `rx_drop` is 1 in that cycle, and `tx_hold` is 0 from the next cycle.
- R4: A valid received character that matches neither value gives `rx_drop` = 0 and leaves `tx_hold` unchanged.
- R5: While enabled and idle, if `rx_fill` >= `fill_hi`, then from the next cycle `ins_req` is 1 with `ins_char` = `xoff_char`. The request holds until a cycle with `ins_ack` = 1.
- R6: After the Xoff is accepted, no further request is raised while `rx_fill` >= `fill_lo`. Once `rx_fill` < `fill_lo`, `ins_req` rises the next cycle with `ins_char` = `xon_char`. After that is accepted, the block returns to idle. Each control character is thus sent once per crossing.
- R7: Whenever `ins_req` is 1, `data_go` is 0, so an inserted character takes priority over queued data.
- R8: Whenever `tx_hold` is 1, `data_go` is 0.
- R9: With `fc_en` = 0, in the same cycle `rx_drop` = 0, `tx_hold` = 0, `ins_req` = 0 and `data_go` = 1. The hold and any pending insertion are cleared, so re-enabling starts released and idle.
- R10: Matching and inserted values always use the current `xon_char` and `xoff_char`. After either value is reprogrammed, the old value passes as data.
- R11: If `xon_char` equals `xoff_char`, a matching character is treated as Xoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_en | input | 1 | Software flow control enable |
| xon_char | input | CHAR_W | Resume character value |
| xoff_char | input | CHAR_W | Pause character value |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | CHAR_W | Received character |
| rx_drop | output | 1 | Discard the presented received character |
| rx_fill | input | FILL_W | Current receive buffer fill count |
| fill_hi | input | FILL_W | Fill level that triggers Xoff |
| fill_lo | input | FILL_W | Fill level below which Xon is sent |
| ins_ack | input | 1 | Transmitter accepted the inserted character |
| ins_req | output | 1 | Request to send a control character |
| ins_char | output | CHAR_W | Control character to send |
| tx_hold | output | 1 | Do not start a new data character |
| data_go | output | 1 | Transmitter may start the next data character |

## Verification
The assertions assume that `ins_ack` only has an effect while `ins_req` is high, that `fill_lo` does not exceed `fill_hi`, and that the configuration inputs are steady around the cycle a character is matched. The stimulus drives every input half a cycle away from the active edge. It keeps the thresholds ordered and changes the character values only in directed phases. Random received characters are biased toward the two control values so that matches are frequent. The fill count moves as a bounded random walk, which makes it cross both thresholds many times.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [1:0] {
    INS_IDLE     = 2'd0,
    INS_SEND_OFF = 2'd1,
    INS_PAUSED   = 2'd2,
    INS_SEND_ON  = 2'd3
  } ins_state_e;
endpackage

// File: rtl/xrx_match.sv
module xrx_match #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  output logic              drop,
  output logic              hold
);
  logic is_off, is_on;
  logic hold_q, hold_d, hold_ce;

  assign is_off = (rx_char == xoff_char);
  assign is_on  = (rx_char == xon_char);

  always_comb begin
    hold_d  = hold_q;
    hold_ce = 1'b0;
    if (!en) begin
      hold_d  = 1'b0;
      hold_ce = 1'b1;
    end else if (rx_valid && is_off) begin
      hold_d  = 1'b1;
      hold_ce = 1'b1;
    end else if (rx_valid && is_on) begin
      hold_d  = 1'b0;
      hold_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_ce) hold_q <= hold_d;
  end

  assign drop = en & rx_valid & (is_off | is_on);
  assign hold = en & hold_q;
endmodule

// File: rtl/xtx_insert.sv
module xtx_insert
  import flow_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] fill_hi,
  input  logic [FILL_W-1:0] fill_lo,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              ack,
  output logic              req,
  output logic [CHAR_W-1:0] char_out
);
  ins_state_e st_q, st_d;
  logic       st_ce;

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = INS_IDLE;
    end else begin
      unique case (st_q)
        INS_IDLE:     if (fill >= fill_hi) st_d = INS_SEND_OFF;
        INS_SEND_OFF: if (ack)             st_d = INS_PAUSED;
        INS_PAUSED:   if (fill < fill_lo)  st_d = INS_SEND_ON;
        INS_SEND_ON:  if (ack)             st_d = INS_IDLE;
        default:                           st_d = INS_IDLE;
      endcase
    end
    st_ce = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= INS_IDLE;
    else if (st_ce) st_q <= st_d;
  end

  assign req      = en & ((st_q == INS_SEND_OFF) | (st_q == INS_SEND_ON));
  assign char_out = (st_q == INS_SEND_ON) ? xon_char : xoff_char;
endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl #(
  parameter int CHAR_W = 8,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_drop,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] fill_hi,
  input  logic [FILL_W-1:0] fill_lo,
  input  logic              ins_ack,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char,
  output logic              tx_hold,
  output logic              data_go
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  xrx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (fc_en),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .xon_char (xon_char),
    .xoff_char(xoff_char),
    .drop     (rx_drop),
    .hold     (tx_hold)
  );

  xtx_insert #(.CHAR_W(CHAR_W), .FILL_W(FILL_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (fc_en),
    .fill     (rx_fill),
    .fill_hi  (fill_hi),
    .fill_lo  (fill_lo),
    .xon_char (xon_char),
    .xoff_char(xoff_char),
    .ack      (ins_ack),
    .req      (ins_req),
    .char_out (ins_char)
  );

  assign data_go = ~tx_hold & ~ins_req;
endmodule

// File: rtl/flow_ctrl_checker.sv
module flow_ctrl_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_en,
  input logic [CHAR_W-1:0] xon_char,
  input logic [CHAR_W-1:0] xoff_char,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_drop,
  input logic              ins_ack,
  input logic              ins_req,
  input logic              tx_hold,
  input logic              data_go
);
  assert_xoff_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && rx_valid && rx_char == xoff_char) |=> (tx_hold || !fc_en));

  assert_xon_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && rx_valid && rx_char == xon_char && rx_char != xoff_char) |=> !tx_hold);

  assert_drop_needs_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> rx_valid);

  assert_req_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack) |=> (ins_req || !fc_en));

  assert_insert_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |-> !data_go);

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> !data_go);

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |-> (!tx_hold && !ins_req && !rx_drop && data_go));
endmodule

bind inband_flow_ctrl flow_ctrl_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .fc_en    (fc_en),
  .xon_char (xon_char),
  .xoff_char(xoff_char),
  .rx_valid (rx_valid),
  .rx_char  (rx_char),
  .rx_drop  (rx_drop),
  .ins_ack  (ins_ack),
  .ins_req  (ins_req),
  .tx_hold  (tx_hold),
  .data_go  (data_go)
);

// File: tb/tb_inband_flow_ctrl.sv
module tb_inband_flow_ctrl;
  localparam int CW = 8;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fc_en;
  logic [CW-1:0] xon_char, xoff_char, rx_char, ins_char;
  logic          rx_valid, rx_drop, ins_ack, ins_req, tx_hold, data_go;
  logic [FW-1:0] rx_fill, fill_hi, fill_lo;

  int n_chk = 0, n_fail = 0;
  bit m_hold;
  int m_st;
  bit done = 0;

  always #2 clk = ~clk;

  inband_flow_ctrl #(.CHAR_W(CW), .FILL_W(FW)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_drop(bit en, bit v, logic [CW-1:0] c);
    return en && v && (c == xoff_char || c == xon_char);
  endfunction

  // one cycle: drive at negedge, check outputs, advance model at posedge
  task automatic step(bit en, bit v, logic [CW-1:0] c, logic [FW-1:0] f, bit ack);
    bit e_hold, e_req;
    string dtag;
    @(negedge clk);
    fc_en = en; rx_valid = v; rx_char = c; rx_fill = f; ins_ack = ack;
    #1;
    e_hold = en && m_hold;
    e_req  = en && (m_st == 1 || m_st == 3);
    if (!en) dtag = "R9";
    else if (v && c == xoff_char) dtag = "R2";
    else if (v && c == xon_char) dtag = "R3";
    else dtag = "R4";
    check(dtag, rx_drop, exp_drop(en, v, c));
    check(en ? "R2" : "R9", tx_hold, e_hold);
    check(m_st >= 2 ? "R6" : "R5", ins_req, e_req);
    if (e_req) check(m_st == 3 ? "R6" : "R5", ins_char, (m_st == 3) ? xon_char : xoff_char);
    check(e_req ? "R7" : "R8", data_go, !e_hold && !e_req);
    if (!en) begin
      m_hold = 0; m_st = 0;
    end else begin
      if (v && c == xoff_char) m_hold = 1;
      else if (v && c == xon_char) m_hold = 0;
      case (m_st)
        0: if (f >= fill_hi) m_st = 1;
        1: if (ack) m_st = 2;
        2: if (f < fill_lo) m_st = 3;
        default: if (ack) m_st = 0;
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int fill;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; fc_en = 1; rx_valid = 0; rx_char = 0; rx_fill = 0; ins_ack = 0;
    xon_char = 8'h11; xoff_char = 8'h13; fill_hi = 6'd48; fill_lo = 6'd16;
    m_hold = 0; m_st = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", tx_hold, 0); check("R1", ins_req, 0); check("R1", data_go, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", data_go, 1);

    // receive matching
    step(1, 1, 8'h41, 0, 0);
    step(1, 1, 8'h13, 0, 0);
    step(1, 1, 8'h42, 0, 0);
    #0 check("R2", tx_hold, 1);
    step(1, 0, 8'h00, 0, 0);
    step(1, 1, 8'h11, 0, 0);
    step(1, 0, 8'h00, 0, 0);
    check("R3", tx_hold, 0);

    // Xoff insertion, once per crossing, then Xon
    step(1, 0, 0, 50, 0);
    step(1, 0, 0, 50, 0);
    check("R5", ins_req, 1); check("R5", ins_char, 8'h13); check("R7", data_go, 0);
    step(1, 0, 0, 50, 0);
    step(1, 0, 0, 50, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 30, 0);
    check("R6", ins_req, 0);
    step(1, 0, 0, 10, 0);
    step(1, 0, 0, 10, 0);
    check("R6", ins_req, 1); check("R6", ins_char, 8'h11);
    step(1, 0, 0, 10, 1);
    step(1, 0, 0, 10, 0);
    check("R6", ins_req, 0);

    // equal values act as Xoff
    xon_char = 8'h55; xoff_char = 8'h55;
    step(1, 1, 8'h55, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R11", tx_hold, 1);

    // reprogramming
    xon_char = 8'h11; xoff_char = 8'h7E;
    step(1, 1, 8'h11, 0, 0);
    step(1, 1, 8'h13, 0, 0);
    check("R10", rx_drop, 0);
    step(1, 1, 8'h7E, 0, 0);
    check("R10", rx_drop, 1);

    // disable while held and requesting
    step(1, 0, 0, 55, 0);
    step(1, 0, 0, 55, 0);
    step(0, 1, 8'h7E, 55, 0);
    check("R9", rx_drop, 0); check("R9", tx_hold, 0);
    check("R9", ins_req, 0); check("R9", data_go, 1);
    step(1, 0, 0, 0, 0);
    check("R9", tx_hold, 0);

    // constrained random
    xoff_char = 8'h13;
    fill = 0;
    for (int i = 0; i < 6000; i++) begin
      int sel;
      logic [CW-1:0] c;
      sel = $urandom_range(0, 9);
      c = (sel < 2) ? xoff_char : (sel < 4) ? xon_char : 8'($urandom);
      fill = fill + $urandom_range(0, 6) - 3;
      if (fill < 0) fill = 0;
      if (fill > 63) fill = 63;
      step($urandom_range(0, 31) != 0, $urandom_range(0, 1) == 1, c,
           FW'(fill), $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule